// File: doc/BRIEF.md
# Real-Time Clock Register Front End

This block is the byte-wide host-facing register file of a real-time clock. The host reaches it through two ports that share one write strobe. A write to the index port selects a register. Writes to the data port then store into the selected register, and the read bus always shows the byte held at the current index. The low indices hold the clock and calendar bytes. Four status registers sit above them. Two of these are writable and set the time base, the rate and the data format. The other two read as zero.

The block accepts only one narrow configuration: a 32.768 kHz time base with a 1024 Hz rate, and binary 24-hour data format. Any write that asks for something else is rejected, and a one-cycle error pulse reports it. The periodic interrupt enable bit in the format register starts and stops a divider that counts input ticks. The divider emits a one-cycle interrupt pulse every `IRQ_DIV` ticks. Calendar rollover and alarm matching belong to other logic.

Top module: `rtc_regfile`

## Requirements
- R1: An index-port write with a value above 0x0D leaves the current index unchanged and raises `cfg_err`.
- R2: An index-port write with a value of 0x0D or less selects that register. Data-port writes never change the index, and `rd_data` always shows the byte at the current index.
- R3: A data-port write while the index is below 0x0A stores the byte into the clock/calendar byte at that index and touches no other register.
- R4: Status register A (index 0x0A) accepts only 0x26, which is time-base code 0x20 ORed with rate code 0x06. Any other value leaves it unchanged and raises `cfg_err`.
- R5: Status register B (index 0x0B) ignores bit 6 (periodic enable) and bit 3 (square-wave enable) in its check. The remaining bits must equal 0x06 (bit 2 binary, bit 1 24-hour). Otherwise the register is unchanged and `cfg_err` is raised.
- R6: Status registers C (0x0C) and D (0x0D) read as 0x00. Writes to them have no effect and raise no error.
- R7: While bit 6 of status register B is set, `irq` pulses high for exactly one cycle on every `IRQ_DIV`-th `tick_in` pulse. While the bit is clear, `irq` stays low and the tick divider is held at zero.
- R8: After a synchronous reset the index is 0, all clock/calendar bytes are 0, A holds 0x26, B holds 0x06, and `irq` and `cfg_err` are low.
- R9: `cfg_err` is high only in the cycle after an illegal write and is low in every other cycle.
- R10: Rewriting status register B with bit 6 set while the divider is already running does not restart the divider count.

Timing: writes take effect at the clock edge where `wr_en` is sampled. The `irq` and `cfg_err` pulses appear in the cycle after the edge that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for either port |
| wr_port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_data | input | 8 | Write byte |
| tick_in | input | 1 | Input tick pulse driving the periodic divider |
| rd_data | output | 8 | Byte held at the current index |
| irq | output | 1 | One-cycle periodic interrupt pulse |
| cfg_err | output | 1 | One-cycle pulse after an illegal write |

## Verification
A corrupted index shows up at once as a wrong `rd_data` byte in the next sampled cycle, so every check reads back through the index after writing. Wrongly accepting an illegal status value shows up one cycle later in two places: `cfg_err` stays low, and the read-back byte differs from the kept value. A divider that loses its count, restarts or keeps running while disabled moves the `irq` pulse by one or more ticks. For that reason `irq` is sampled after every single tick, across enable, rewrite and disable sequences.

// File: rtl/rtcr_pkg.sv
package rtcr_pkg;
   // status register A: time base (bits 6:4) and rate (bits 3:0)
   localparam logic [7:0] STAT_A_LEGAL = 8'h20 | 8'h06;
   // status register B bit positions
   localparam int B_PIE_BIT  = 6;
   localparam int B_SQW_BIT  = 3;
   localparam logic [7:0] B_DONT_CARE = (8'h1 << B_PIE_BIT) | (8'h1 << B_SQW_BIT);
   localparam logic [7:0] B_REQUIRED  = 8'h04 | 8'h02;
   localparam logic [7:0] STAT_B_RESET = B_REQUIRED;

   function automatic logic stat_b_legal(input logic [7:0] v);
      return (v & ~B_DONT_CARE) == B_REQUIRED;
   endfunction
endpackage

// File: rtl/rtcr_index.sv
module rtcr_index #(
   parameter int DW      = 8,
   parameter int IDX_W   = 4,
   parameter int MAX_IDX = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr,
   input  logic [DW-1:0]    wdata,
   output logic [IDX_W-1:0] idx,
   output logic             err
);
   localparam logic [DW-1:0] MAX_V = DW'(MAX_IDX);

   generate
      if (MAX_IDX >= (1 << IDX_W)) begin : g_bad_w
         $error("IDX_W too narrow for MAX_IDX");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         idx <= '0;
         err <= 1'b0;
      end else begin
         err <= 1'b0;
         if (wr) begin
            if (wdata > MAX_V) err <= 1'b1;
            else               idx <= wdata[IDX_W-1:0];
         end
      end
   end

   // R1
   idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && wdata > MAX_V) |=> ($stable(idx) && err));
   // R2
   idx_range_chk: assert property (@(posedge clk) disable iff (rst)
      idx <= IDX_W'(MAX_IDX));
endmodule

// File: rtl/rtcr_store.sv
module rtcr_store
   import rtcr_pkg::*;
#(
   parameter int DW       = 8,
   parameter int IDX_W    = 4,
   parameter int NUM_TIME = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rd,
   output logic             pie,
   output logic             err
);
   localparam logic [IDX_W-1:0] IX_A = IDX_W'(NUM_TIME);
   localparam logic [IDX_W-1:0] IX_B = IDX_W'(NUM_TIME + 1);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("status encodings need DW of 8");
      end
   endgenerate

   logic [DW-1:0] tm [NUM_TIME];
   logic [DW-1:0] sa, sb;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_TIME; i++) tm[i] <= '0;
         sa  <= STAT_A_LEGAL;
         sb  <= STAT_B_RESET;
         err <= 1'b0;
      end else begin
         err <= 1'b0;
         if (wr) begin
            if (idx < IX_A) begin
               tm[idx] <= wdata;
            end else if (idx == IX_A) begin
               if (wdata == STAT_A_LEGAL) sa <= wdata;
               else                       err <= 1'b1;
            end else if (idx == IX_B) begin
               if (stat_b_legal(wdata))   sb <= wdata;
               else                       err <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      if (idx < IX_A)       rd = tm[idx];
      else if (idx == IX_A) rd = sa;
      else if (idx == IX_B) rd = sb;
      else                  rd = '0;
   end

   assign pie = sb[B_PIE_BIT];

   // R4
   stat_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && idx == IX_A && wdata != STAT_A_LEGAL) |=> ($stable(sa) && err));
   // R5
   stat_b_form_chk: assert property (@(posedge clk) disable iff (rst)
      (sb & ~B_DONT_CARE) == B_REQUIRED);
   // R4
   stat_a_const_chk: assert property (@(posedge clk) disable iff (rst)
      sa == STAT_A_LEGAL);
endmodule

// File: rtl/rtcr_periodic.sv
module rtcr_periodic #(
   parameter int IRQ_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic tick,
   output logic irq
);
   localparam int CNT_W = (IRQ_DIV > 1) ? $clog2(IRQ_DIV) : 1;

   generate
      if (IRQ_DIV < 1) begin : g_bad_div
         $error("IRQ_DIV must be at least 1");
      end
      if (IRQ_DIV == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst) irq <= 1'b0;
            else     irq <= en && tick;
         end
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(IRQ_DIV - 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt <= '0;
               irq <= 1'b0;
            end else begin
               irq <= 1'b0;
               if (!en) begin
                  cnt <= '0;
               end else if (tick) begin
                  if (cnt == LAST) begin
                     cnt <= '0;
                     irq <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
         end
         // R7
         cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(en) |-> cnt == '0);
      end
   endgenerate

   // R7
   irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
      irq |-> $past(en && tick));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
   parameter int NUM_TIME = 10,
   parameter int IRQ_DIV  = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic       wr_port_sel,
   input  logic [7:0] wr_data,
   input  logic       tick_in,
   output logic [7:0] rd_data,
   output logic       irq,
   output logic       cfg_err
);
   localparam int DW      = 8;
   localparam int MAX_IDX = NUM_TIME + 3;
   localparam int IDX_W   = $clog2(MAX_IDX + 1);

   logic [IDX_W-1:0] idx;
   logic idx_err, st_err, pie;

   rtcr_index #(.DW(DW), .IDX_W(IDX_W), .MAX_IDX(MAX_IDX)) u_index (
      .clk(clk), .rst(rst), .wr(wr_en && !wr_port_sel), .wdata(wr_data),
      .idx(idx), .err(idx_err));

   rtcr_store #(.DW(DW), .IDX_W(IDX_W), .NUM_TIME(NUM_TIME)) u_store (
      .clk(clk), .rst(rst), .wr(wr_en && wr_port_sel), .idx(idx),
      .wdata(wr_data), .rd(rd_data), .pie(pie), .err(st_err));

   rtcr_periodic #(.IRQ_DIV(IRQ_DIV)) u_periodic (
      .clk(clk), .rst(rst), .en(pie), .tick(tick_in), .irq(irq));

   assign cfg_err = idx_err | st_err;

   // R9
   err_src_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> $past(wr_en));
   // R2
   idx_data_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_port_sel) |=> $stable(idx));
endmodule

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
   logic clk = 1'b0, rst = 1'b1;
   logic wr_en = 1'b0, wr_port_sel = 1'b0, tick_in = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic irq, cfg_err;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtc_regfile #(.NUM_TIME(10), .IRQ_DIV(4)) i_rtc_regfile (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port_sel(wr_port_sel),
      .wr_data(wr_data), .tick_in(tick_in), .rd_data(rd_data),
      .irq(irq), .cfg_err(cfg_err));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_port_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input logic [7:0] exp_irq, input string req);
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
      chk(req, {7'd0, irq}, exp_irq);
   endtask

   task automatic t_reset;
      chk("R8 rd idx0", rd_data, 8'h00);
      chk("R8 irq", {7'd0, irq}, 8'h00);
      chk("R8 err", {7'd0, cfg_err}, 8'h00);
      wr(1'b0, 8'h0B); chk("R8 B reset", rd_data, 8'h06);
      wr(1'b0, 8'h0A); chk("R8 A reset", rd_data, 8'h26);
   endtask

   task automatic t_index;
      wr(1'b0, 8'h05); chk("R2 err", {7'd0, cfg_err}, 8'h00);
      wr(1'b1, 8'hA5); chk("R2 rd", rd_data, 8'hA5);
      wr(1'b1, 8'h5A); chk("R2 idx kept", rd_data, 8'h5A);
      wr(1'b0, 8'h0E); chk("R1 err", {7'd0, cfg_err}, 8'h01);
      chk("R1 idx kept", rd_data, 8'h5A);
      @(negedge clk); chk("R9 err one cycle", {7'd0, cfg_err}, 8'h00);
      wr(1'b0, 8'hFF); chk("R1 err ff", {7'd0, cfg_err}, 8'h01);
      chk("R1 idx kept ff", rd_data, 8'h5A);
      wr(1'b0, 8'h0D); chk("R2 max idx", {7'd0, cfg_err}, 8'h00);
      chk("R6 D reads 0", rd_data, 8'h00);
   endtask

   task automatic t_time;
      for (int i = 0; i < 10; i++) begin
         wr(1'b0, 8'(i)); wr(1'b1, 8'h30 + 8'(i));
      end
      for (int i = 0; i < 10; i++) begin
         wr(1'b0, 8'(i)); chk("R3 time byte", rd_data, 8'h30 + 8'(i));
      end
      wr(1'b0, 8'h0A); chk("R3 A untouched", rd_data, 8'h26);
   endtask

   task automatic t_stat_a;
      wr(1'b0, 8'h0A);
      wr(1'b1, 8'h26); chk("R4 legal err", {7'd0, cfg_err}, 8'h00);
      chk("R4 legal rd", rd_data, 8'h26);
      wr(1'b1, 8'h20); chk("R4 illegal err", {7'd0, cfg_err}, 8'h01);
      chk("R4 kept", rd_data, 8'h26);
      wr(1'b1, 8'h06); chk("R4 illegal err2", {7'd0, cfg_err}, 8'h01);
   endtask

   task automatic t_stat_b;
      wr(1'b0, 8'h0B);
      wr(1'b1, 8'h0E); chk("R5 sqw ok", {7'd0, cfg_err}, 8'h00);
      chk("R5 sqw rd", rd_data, 8'h0E);
      wr(1'b1, 8'h02); chk("R5 no bin err", {7'd0, cfg_err}, 8'h01);
      chk("R5 kept", rd_data, 8'h0E);
      wr(1'b1, 8'h86); chk("R5 bit7 err", {7'd0, cfg_err}, 8'h01);
      wr(1'b1, 8'h06); chk("R5 plain ok", rd_data, 8'h06);
   endtask

   task automatic t_stat_cd;
      wr(1'b0, 8'h0C);
      wr(1'b1, 8'hFF); chk("R6 C err", {7'd0, cfg_err}, 8'h00);
      chk("R6 C rd", rd_data, 8'h00);
      wr(1'b0, 8'h0D);
      wr(1'b1, 8'hFF); chk("R6 D err", {7'd0, cfg_err}, 8'h00);
      chk("R6 D rd", rd_data, 8'h00);
   endtask

   task automatic t_periodic;
      tick(8'h00, "R7 disabled"); tick(8'h00, "R7 disabled");
      tick(8'h00, "R7 disabled"); tick(8'h00, "R7 disabled");
      wr(1'b0, 8'h0B); wr(1'b1, 8'h46);
      chk("R7 pie rd", rd_data, 8'h46);
      tick(8'h00, "R7 t1"); tick(8'h00, "R7 t2"); tick(8'h00, "R7 t3");
      tick(8'h01, "R7 t4 irq");
      @(negedge clk); chk("R7 one cycle", {7'd0, irq}, 8'h00);
      tick(8'h00, "R10 t1"); tick(8'h00, "R10 t2");
      wr(1'b1, 8'h46);
      tick(8'h00, "R10 t3");
      tick(8'h01, "R10 no restart");
      tick(8'h00, "R7 a1"); tick(8'h00, "R7 a2");
      wr(1'b1, 8'h06);
      for (int i = 0; i < 5; i++) tick(8'h00, "R7 stopped");
      wr(1'b1, 8'h4E);
      tick(8'h00, "R7 r1"); tick(8'h00, "R7 r2"); tick(8'h00, "R7 r3");
      tick(8'h01, "R7 divider cleared");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_index();
      t_time();
      t_stat_a();
      t_stat_b();
      t_stat_cd();
      t_periodic();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule